// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address using one flat page table kept in memory. Pages are 4 KB. The upper 20 bits of the address select a table entry and the low 12 bits pass through unchanged. A table base address and a table entry count come in as inputs. The walker latches both when it accepts a request.

A requester presents an address and a read/write flag over a valid/ready handshake. The walker first checks the page number against the entry count. If the page is in range, it reads the entry over a single memory port and checks the entry's valid bit. If the page is mapped, the walker forms the physical address and updates the access-tracking bits. It writes the entry back only when those bits change. A page that is out of range or unmapped returns a fault, which the system's software then handles. The response stays on the port until the requester takes it.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both `rsp_valid_o` and `mem_req_o` are 0.
- R2: A request is accepted only in the idle state. From acceptance until the response is consumed, `req_ready_o` stays 0, so at most one translation is in flight.
- R3: If the page number (address bits 31:12) is greater than or equal to `tbl_len_i`, the response has `rsp_fault_o`=1, `rsp_oob_o`=1 and `rsp_paddr_o`=0, and no memory access is made.
- R4: For an in-range page, exactly one entry read is made (`mem_we_o`=0) at address `tbl_base_i` + page number × 4.
- R5: If entry bit 0 (valid) is 0, the response has `rsp_fault_o`=1, `rsp_oob_o`=0 and `rsp_paddr_o`=0, and no write is made.
- R6: If the entry is valid, the response has `rsp_fault_o`=0 and `rsp_paddr_o` = {entry bits 31:12, address bits 11:0}.
- R7: A successful access writes back the entry with bit 1 (reference) set. All other bits are kept as read, except bit 2 under R8. The write goes to the same address as the read.
- R8: A successful write access (`req_write_i`=1) also sets bit 2 (dirty) in the written-back entry.
- R9: The write-back is issued only when it changes bit 1 or bit 2. Otherwise there is no memory write.
- R10: While `rsp_valid_o`=1 and `rsp_ready_i`=0, the response signals stay valid and unchanged.
- R11: While `mem_req_o`=1 and `mem_gnt_i`=0, the request stays asserted and `mem_addr_o`, `mem_we_o` and `mem_wdata_o` do not change. Read data is taken on a later `mem_rvalid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_base_i | input | 32 | Byte address of the page table |
| tbl_len_i | input | 21 | Number of entries in the table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Access is a write |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Requester accepts the response |
| rsp_paddr_o | output | 32 | Physical address (zero on fault) |
| rsp_fault_o | output | 1 | Translation failed |
| rsp_oob_o | output | 1 | Fault caused by the page-number bound |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Entry address |
| mem_wdata_o | output | 32 | Entry write data |
| mem_gnt_i | input | 1 | Memory accepted the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry read data |

## Verification
Write-back suppression is the hardest case to reach from the ports. It needs an entry whose reference bit is already set, or whose dirty bit is already set under a write, so that the write is skipped. The bench gets there in two ways. Some entries start with random status bits. Others are translated several times, so earlier write-backs set the bits before a later access. A memory model with random grant and read-return latency stretches every wait state. Directed cases cover the page-number bound: a zero-length table, a page exactly at the bound, the last legal page, and the largest page number.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W      = 32;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned VPN_W     = VA_W - OFF_W;
  localparam int unsigned PTE_W     = 32;
  localparam int unsigned PTE_SHIFT = 2;
  localparam int unsigned LEN_W     = VPN_W + 1;
  localparam int unsigned RSVD_W    = PTE_W - VPN_W - 3;

  typedef struct packed {
    logic [VPN_W-1:0]  ppn;
    logic [RSVD_W-1:0] rsvd;
    logic              dirty;
    logic              refd;
    logic              valid;
  } pte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WB_REQ,
    ST_RESP
  } walk_state_e;
endpackage

// File: rtl/ptw_vaddr_split.sv
module ptw_vaddr_split
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [VA_W-1:0]  base_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [OFF_W-1:0] off_o,
  output logic             in_bounds_o,
  output logic [VA_W-1:0]  pte_addr_o
);
  localparam int unsigned PAD_W = VA_W - VPN_W - PTE_SHIFT;

  logic [VPN_W-1:0] vpn;

  assign vpn         = vaddr_i[VA_W-1:OFF_W];
  assign off_o       = vaddr_i[OFF_W-1:0];
  assign in_bounds_o = {1'b0, vpn} < len_i;
  assign pte_addr_o  = base_i + {{PAD_W{1'b0}}, vpn, {PTE_SHIFT{1'b0}}};
endmodule

// File: rtl/ptw_pte_update.sv
module ptw_pte_update
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic             is_write_i,
  output logic [PTE_W-1:0] pte_o,
  output logic [VPN_W-1:0] ppn_o,
  output logic             valid_o,
  output logic             need_wb_o
);
  pte_t cur, nxt;

  always_comb begin
    cur       = pte_t'(pte_i);
    nxt       = cur;
    nxt.refd  = 1'b1;
    nxt.dirty = cur.dirty | is_write_i;
  end

  assign pte_o     = nxt;
  assign ppn_o     = cur.ppn;
  assign valid_o   = cur.valid;
  assign need_wb_o = (nxt.refd != cur.refd) || (nxt.dirty != cur.dirty);
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             in_bounds_i,
  input  logic [VA_W-1:0]  pte_addr_i,
  output logic             write_q_o,
  input  logic [PTE_W-1:0] upd_pte_i,
  input  logic [VPN_W-1:0] upd_ppn_i,
  input  logic             upd_valid_i,
  input  logic             upd_need_wb_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [VA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic             rsp_oob_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [VA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i
);
  walk_state_e      state_q, state_d;
  logic [OFF_W-1:0] off_q;
  logic [VA_W-1:0]  addr_q;
  logic [PTE_W-1:0] wdata_q;
  logic [VA_W-1:0]  paddr_q;
  logic             write_q, fault_q, oob_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid_i) state_d = in_bounds_i ? ST_RD_REQ : ST_RESP;
      ST_RD_REQ:  if (mem_gnt_i) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rvalid_i)
                    state_d = (upd_valid_i && upd_need_wb_i) ? ST_WB_REQ : ST_RESP;
      ST_WB_REQ:  if (mem_gnt_i) state_d = ST_RESP;
      ST_RESP:    if (rsp_ready_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      paddr_q <= '0;
      write_q <= 1'b0;
      fault_q <= 1'b0;
      oob_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        off_q   <= off_i;
        addr_q  <= pte_addr_i;
        write_q <= req_write_i;
        paddr_q <= '0;
        fault_q <= !in_bounds_i;
        oob_q   <= !in_bounds_i;
      end
      if (state_q == ST_RD_WAIT && mem_rvalid_i) begin
        fault_q <= !upd_valid_i;
        paddr_q <= upd_valid_i ? {upd_ppn_i, off_q} : '0;
        wdata_q <= upd_pte_i;
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_paddr_o = paddr_q;
  assign rsp_fault_o = fault_q;
  assign rsp_oob_o   = oob_q;
  assign mem_req_o   = (state_q == ST_RD_REQ) || (state_q == ST_WB_REQ);
  assign mem_we_o    = (state_q == ST_WB_REQ);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign write_q_o   = write_q;

  // R2
  idle_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!rsp_valid_o && !mem_req_o));

  // R3
  oob_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_oob_o) |-> (rsp_fault_o && rsp_paddr_o == '0));

  // R7
  wb_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[1] && mem_wdata_o[0]));

  // R10
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_paddr_o)
      && $stable(rsp_fault_o) && $stable(rsp_oob_o)));

  // R11
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VA_W-1:0]  tbl_base_i,
  input  logic [LEN_W-1:0] tbl_len_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [VA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic             rsp_oob_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [VA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  logic [OFF_W-1:0] off;
  logic             in_bounds;
  logic [VA_W-1:0]  pte_addr;
  logic             write_q;
  logic [PTE_W-1:0] upd_pte;
  logic [VPN_W-1:0] upd_ppn;
  logic             upd_valid, upd_need_wb;

  ptw_vaddr_split u_split (
    .vaddr_i     (req_vaddr_i),
    .base_i      (tbl_base_i),
    .len_i       (tbl_len_i),
    .off_o       (off),
    .in_bounds_o (in_bounds),
    .pte_addr_o  (pte_addr)
  );

  ptw_pte_update u_update (
    .pte_i      (mem_rdata_i),
    .is_write_i (write_q),
    .pte_o      (upd_pte),
    .ppn_o      (upd_ppn),
    .valid_o    (upd_valid),
    .need_wb_o  (upd_need_wb)
  );

  ptw_walk_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_write_i   (req_write_i),
    .off_i         (off),
    .in_bounds_i   (in_bounds),
    .pte_addr_i    (pte_addr),
    .write_q_o     (write_q),
    .upd_pte_i     (upd_pte),
    .upd_ppn_i     (upd_ppn),
    .upd_valid_i   (upd_valid),
    .upd_need_wb_i (upd_need_wb),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_ready_i   (rsp_ready_i),
    .rsp_paddr_o   (rsp_paddr_o),
    .rsp_fault_o   (rsp_fault_o),
    .rsp_oob_o     (rsp_oob_o),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_gnt_i     (mem_gnt_i),
    .mem_rvalid_i  (mem_rvalid_i)
  );
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  localparam int TBL = 64;
  localparam logic [31:0] BASE = 32'h0004_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] tbl_base = BASE;
  logic [20:0] tbl_len = 21'd40;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_fault, rsp_oob;
  logic [31:0] rsp_paddr;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  pt_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tbl_base_i(tbl_base), .tbl_len_i(tbl_len),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault), .rsp_oob_o(rsp_oob),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata)
  );

  logic [31:0] tbl [TBL];
  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0, cyc = 0;
  logic [31:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
  logic [31:0] cap_addr = '0, cap_wdata = '0;
  logic cap_we = 1'b0;
  int rv_cnt = 0, rv_idx = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: random grant and read-return latency
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (rv_cnt > 0) begin
      rv_cnt--;
      if (rv_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = (rv_idx < TBL) ? tbl[rv_idx] : 32'h0;
      end
    end
    if (mem_gnt) begin
      int idx;
      mem_gnt = 1'b0;
      idx = int'((cap_addr - BASE) >> 2);
      if (cap_we) begin
        n_wr++; wr_addr = cap_addr; wr_data = cap_wdata;
        if (idx >= 0 && idx < TBL) tbl[idx] = cap_wdata;
      end else begin
        n_rd++; rd_addr = cap_addr; rv_idx = idx; rv_cnt = 1 + int'($urandom % 3);
      end
    end else if (mem_req && ($urandom % 3 == 0)) begin
      mem_gnt = 1'b1; cap_addr = mem_addr; cap_we = mem_we; cap_wdata = mem_wdata;
    end
  end

  task automatic xlate(input logic [31:0] va, input bit wr);
    logic [19:0] vpn;
    logic [31:0] e, exp_pa, exp_wd;
    bit inb, wb;
    int hold;
    vpn = va[31:12];
    inb = {1'b0, vpn} < tbl_len;
    e = inb ? tbl[vpn] : 32'h0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; n_rd = 0; n_wr = 0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2", "ready low after accept", {31'b0, req_ready}, 32'h0);
    while (!rsp_valid) begin
      @(negedge clk);
      if (!rsp_valid)
        chk(!req_ready, "R2", "ready low while busy", {31'b0, req_ready}, 32'h0);
    end
    #1;
    if (!inb) begin
      chk(rsp_fault && rsp_oob && rsp_paddr == 0, "R3", "bound fault",
          {rsp_fault, rsp_oob, rsp_paddr[29:0]}, 32'hC000_0000);
      chk(n_rd == 0 && n_wr == 0, "R3", "no memory access", n_rd + n_wr, 0);
    end else begin
      chk(n_rd == 1 && rd_addr == BASE + {10'b0, vpn, 2'b00}, "R4", "entry read addr",
          rd_addr, BASE + {10'b0, vpn, 2'b00});
      if (!e[0]) begin
        chk(rsp_fault && !rsp_oob && rsp_paddr == 0, "R5", "invalid fault",
            {rsp_fault, rsp_oob, rsp_paddr[29:0]}, 32'h8000_0000);
        chk(n_wr == 0, "R5", "no write on invalid", n_wr, 0);
      end else begin
        exp_pa = {e[31:12], va[11:0]};
        chk(!rsp_fault && rsp_paddr == exp_pa, "R6", "paddr", rsp_paddr, exp_pa);
        exp_wd = e | 32'h2 | (wr ? 32'h4 : 32'h0);
        wb = !e[1] || (wr && !e[2]);
        chk(n_wr == (wb ? 1 : 0), "R9", "write-back count", n_wr, wb ? 1 : 0);
        if (wb) begin
          chk(wr_data == exp_wd, wr ? "R8" : "R7", "write-back data", wr_data, exp_wd);
          chk(wr_addr == rd_addr, "R7", "write-back addr", wr_addr, rd_addr);
        end
      end
    end
    hold = int'($urandom % 4);
    for (int i = 0; i < hold; i++) begin
      logic [31:0] pa;
      logic fl;
      pa = rsp_paddr; fl = rsp_fault;
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa && rsp_fault == fl, "R10", "response held",
          rsp_paddr, pa);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < TBL; i++)
      tbl[i] = {$urandom, 1'b0} & 32'hFFFF_F3FF | (($urandom % 4 != 0) ? 32'h1 : 32'h0);
    #1;
    chk(req_ready && !rsp_valid && !mem_req, "R1", "reset state",
        {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: fresh valid entry, read then read again (no write-back), then writes
    tbl[5] = 32'hABCDE001;
    xlate(32'h0000_5123, 1'b0);
    xlate(32'h0000_5FFF, 1'b0);
    xlate(32'h0000_5004, 1'b1);
    xlate(32'h0000_5008, 1'b1);
    tbl[6] = 32'h12345000;
    xlate(32'h0000_6010, 1'b1);
    // bound corners
    xlate({20'd39, 12'h0AB}, 1'b0);
    xlate({20'd40, 12'h0AB}, 1'b0);
    xlate({20'hFFFFF, 12'hFFF}, 1'b1);
    tbl_len = 21'd0;
    xlate(32'h0000_0000, 1'b0);
    tbl_len = 21'd64;
    xlate({20'd63, 12'h001}, 1'b1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      if (n % 50 == 0) tbl_len = 21'(16 + $urandom % 49);
      xlate({20'($urandom % 72), 12'($urandom)}, 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule